// File: doc/BRIEF.md
# Interleaved DRAM Refresh and Access Sequencer

This block sits between a slow 8-bit CPU bus that has no wait-state input and a multiplexed DRAM array built from two 64K x 4 devices forming one byte. It runs from a fast reference clock and derives from it the CPU phase-2 clock. Each CPU cycle is split into two halves. The low half carries a RAS-only refresh of one row, taken from an internal 8-bit counter. The high half carries the CPU access itself. Because refresh fits inside every cycle, the CPU never has to be stalled.

Within each half, the row strobe stays inactive for a fixed hold time after the clock level changes, and then goes active. After a short lag, the row/column select moves the address bus from the row to the column. After one more lag, the column strobe goes active. The column strobe appears only in the CPU half, and only on the one of four bank lines chosen by the two top CPU address bits. The row mapping places A14 on MA0 and A15 on MA7, so lower-density parts that decode only MA1..MA6 as row bits can be fitted without rewiring. Write enable and the data-direction control follow the column strobe and the CPU read/write line.

Top module: `dram_interleave_seq`

## Requirements
- R1: `phi2` is low for HALF_TICKS reference ticks and then high for HALF_TICKS ticks, repeating. The first output tick after reset is tick 0 of a low half.
- R2: `ras_n` is high for the first RAS_HOLD ticks of each half and low for the rest of that half, which gives two row strobes per CPU cycle.
- R3: `mux_n` (0 = column address, 1 = row address) goes low MUX_LAG ticks after `ras_n` falls, and returns high together with `ras_n`. It is never low while `ras_n` is high.
- R4: The column strobe goes active CAS_LAG ticks after `mux_n` falls, only while `phi2` is high, and lasts until the end of that half. No `cas_n` line is ever low while `phi2` is low.
- R5: During the column strobe, exactly one line of `cas_n[3:0]` is low: the line whose index equals CPU address bits [15:14]. All other lines stay high.
- R6: In every CPU half, the column strobe is active for at least CAS_MIN_TICKS ticks before `phi2` falls. With the default values this is exactly 10 ticks.
- R7: During the whole low half, `ma` carries the refresh row. The refresh row is 0 for the first CPU cycle after reset and increases by 1 every CPU cycle, wrapping from 255 to 0.
- R8: During the high half, `ma` carries {A15, A13..A8, A14} (MSB first, so MA0 = A14 and MA7 = A15) while `mux_n` is high, and A7..A0 while `mux_n` is low.
- R9: `we_n` is low only while the column strobe is active and `cpu_rd` is 0 (a write).
- R10: `dq_to_cpu` is high only while the column strobe is active and `cpu_rd` is 1 (a read).
- R11: While reset is held, `phi2` = 0, `ras_n` = 1, `mux_n` = 1, `cas_n` = 4'hF, `we_n` = 1, `dq_to_cpu` = 0 and `ma` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (one tick) |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rd | input | 1 | CPU read/write, 1 = read, 0 = write |
| phi2 | output | 1 | Generated CPU phase-2 clock |
| ras_n | output | 1 | Row strobe, active low |
| mux_n | output | 1 | Row/column select, 0 = column |
| cas_n | output | 4 | Bank-gated column strobes, active low |
| we_n | output | 1 | DRAM write enable, active low |
| dq_to_cpu | output | 1 | Data buffer direction, 1 = DRAM drives the CPU bus |
| ma | output | 8 | Multiplexed DRAM address |

## Verification
The bench builds the block with its default parameters: 20 ticks per half, a row-strobe hold of 8, lags of 1 and 1, and a column window of at least 10. With these values the column strobe occupies exactly the minimum window, so any lag that is one tick off shows up as a window violation. The 8-bit refresh row wraps within the 262 CPU cycles the bench runs. Every tick of every cycle is compared against a bench-side model, with addresses that cover all four banks and with both reads and writes.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    localparam int CPU_AW = 16;
    localparam int MA_W   = 8;
    localparam int BANKS  = 4;
    localparam int BANK_W = $clog2(BANKS);

    typedef enum logic {
        HALF_REFRESH = 1'b0,
        HALF_CPU     = 1'b1
    } half_e;

    typedef struct packed {
        logic             phi2;
        logic             ras_n;
        logic             mux_n;
        logic [BANKS-1:0] cas_n;
        logic             we_n;
        logic             dq_to_cpu;
        logic [MA_W-1:0]  ma;
    } dram_pins_t;

    localparam dram_pins_t PINS_IDLE = '{
        phi2: 1'b0, ras_n: 1'b1, mux_n: 1'b1, cas_n: {BANKS{1'b1}},
        we_n: 1'b1, dq_to_cpu: 1'b0, ma: {MA_W{1'b0}}
    };

    // Row lines: MA7 = A15, MA6..MA1 = A13..A8, MA0 = A14
    function automatic logic [MA_W-1:0] row_of(input logic [CPU_AW-1:0] a);
        return {a[15], a[13:8], a[14]};
    endfunction

    function automatic logic [MA_W-1:0] col_of(input logic [CPU_AW-1:0] a);
        return a[7:0];
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [CPU_AW-1:0] a);
        return a[CPU_AW-1 -: BANK_W];
    endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer
    import dram_seq_pkg::*;
#(
    parameter int HALF_TICKS = 20,
    localparam int PW = $clog2(HALF_TICKS)
) (
    input  logic          clk,
    input  logic          rst,
    output half_e         half,
    output logic [PW-1:0] pos,
    output logic          half_end
);
    localparam logic [PW-1:0] LAST = PW'(HALF_TICKS - 1);

    assign half_end = (pos == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            half <= HALF_REFRESH;
        end else if (half_end) begin
            pos  <= '0;
            half <= (half == HALF_REFRESH) ? HALF_CPU : HALF_REFRESH;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    p_half_flip_r1: assert property (@(posedge clk) disable iff (rst)
        half_end |=> (pos == '0) && (half != $past(half)));

    p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
        pos <= LAST);

endmodule

// File: rtl/dram_seq_refresh.sv
module dram_seq_refresh #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)      row <= '0;
        else if (adv) row <= row + 1'b1;
    end

    p_row_step_r7: assert property (@(posedge clk) disable iff (rst)
        adv |=> row == ROW_W'($past(row) + 1'b1));

    p_row_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(row));

endmodule

// File: rtl/dram_seq_strobe.sv
module dram_seq_strobe
    import dram_seq_pkg::*;
#(
    parameter int HALF_TICKS    = 20,
    parameter int RAS_HOLD      = 8,
    parameter int MUX_LAG       = 1,
    parameter int CAS_LAG       = 1,
    parameter int CAS_MIN_TICKS = 10,
    localparam int PW = $clog2(HALF_TICKS),
    localparam int LW = $clog2(HALF_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  half_e             half,
    input  logic [PW-1:0]     pos,
    input  logic [MA_W-1:0]   ref_row,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    output dram_pins_t        pins
);
    localparam logic [PW-1:0] RAS_AT = PW'(RAS_HOLD);
    localparam logic [PW-1:0] COL_AT = PW'(RAS_HOLD + MUX_LAG);
    localparam logic [PW-1:0] CAS_AT = PW'(RAS_HOLD + MUX_LAG + CAS_LAG);

    logic             ras_act, col_phase, cas_act;
    logic [BANKS-1:0] cas_sel;
    dram_pins_t       nxt;

    assign ras_act   = (pos >= RAS_AT);
    assign col_phase = (pos >= COL_AT);
    assign cas_act   = (half == HALF_CPU) && (pos >= CAS_AT);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        assign cas_sel[g] = cas_act && (bank_of(cpu_addr) == BANK_W'(g));
    end

    always_comb begin
        nxt           = PINS_IDLE;
        nxt.phi2      = (half == HALF_CPU);
        nxt.ras_n     = !ras_act;
        nxt.mux_n     = !col_phase;
        nxt.cas_n     = ~cas_sel;
        nxt.we_n      = !(cas_act && !cpu_rd);
        nxt.dq_to_cpu = cas_act && cpu_rd;
        if (half == HALF_REFRESH) nxt.ma = ref_row;
        else if (col_phase)       nxt.ma = col_of(cpu_addr);
        else                      nxt.ma = row_of(cpu_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) pins <= PINS_IDLE;
        else     pins <= nxt;
    end

    // Length of the column window in the current CPU half
    logic [LW-1:0] cas_len;
    always_ff @(posedge clk) begin
        if (rst || !pins.phi2)  cas_len <= '0;
        else if (!(&pins.cas_n)) cas_len <= cas_len + 1'b1;
    end

    initial begin
        a_window_fits_r6: assert (HALF_TICKS - (RAS_HOLD + MUX_LAG + CAS_LAG) >= CAS_MIN_TICKS);
    end

    p_cas_window_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pins.phi2) |-> cas_len >= LW'(CAS_MIN_TICKS));

    p_cas_cpu_half_r4: assert property (@(posedge clk) disable iff (rst)
        !(&pins.cas_n) |-> pins.phi2 && !pins.mux_n);

    p_cas_single_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~pins.cas_n));

    p_mux_inside_ras_r3: assert property (@(posedge clk) disable iff (rst)
        !pins.mux_n |-> !pins.ras_n);

    p_we_gated_r9: assert property (@(posedge clk) disable iff (rst)
        !pins.we_n |-> !(&pins.cas_n));

    p_dir_gated_r10: assert property (@(posedge clk) disable iff (rst)
        pins.dq_to_cpu |-> !(&pins.cas_n) && pins.we_n);

endmodule

// File: rtl/dram_interleave_seq.sv
module dram_interleave_seq
    import dram_seq_pkg::*;
#(
    parameter int HALF_TICKS    = 20,
    parameter int RAS_HOLD      = 8,
    parameter int MUX_LAG       = 1,
    parameter int CAS_LAG       = 1,
    parameter int CAS_MIN_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_rd,
    output logic              phi2,
    output logic              ras_n,
    output logic              mux_n,
    output logic [BANKS-1:0]  cas_n,
    output logic              we_n,
    output logic              dq_to_cpu,
    output logic [MA_W-1:0]   ma
);
    localparam int PW = $clog2(HALF_TICKS);

    half_e           half;
    logic [PW-1:0]   pos;
    logic            half_end;
    logic [MA_W-1:0] ref_row;
    dram_pins_t      pins;

    dram_seq_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk(clk), .rst(rst), .half(half), .pos(pos), .half_end(half_end)
    );

    dram_seq_refresh #(.ROW_W(MA_W)) u_refresh (
        .clk(clk), .rst(rst),
        .adv(half_end && (half == HALF_REFRESH)),
        .row(ref_row)
    );

    dram_seq_strobe #(
        .HALF_TICKS(HALF_TICKS), .RAS_HOLD(RAS_HOLD), .MUX_LAG(MUX_LAG),
        .CAS_LAG(CAS_LAG), .CAS_MIN_TICKS(CAS_MIN_TICKS)
    ) u_strobe (
        .clk(clk), .rst(rst), .half(half), .pos(pos), .ref_row(ref_row),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .pins(pins)
    );

    assign phi2      = pins.phi2;
    assign ras_n     = pins.ras_n;
    assign mux_n     = pins.mux_n;
    assign cas_n     = pins.cas_n;
    assign we_n      = pins.we_n;
    assign dq_to_cpu = pins.dq_to_cpu;
    assign ma        = pins.ma;

    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> ras_n && mux_n && (&cas_n) && we_n && !dq_to_cpu && !phi2);

endmodule

// File: tb/dram_interleave_seq_tb_top.sv
module dram_interleave_seq_tb_top;

    localparam int HALF = 20;
    localparam int HOLD = 8;
    localparam int COLP = 9;
    localparam int CASP = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b1;
    logic        phi2, ras_n, mux_n, we_n, dq_to_cpu;
    logic [3:0]  cas_n;
    logic [7:0]  ma;

    int checks = 0;
    int fails  = 0;
    int cyc_idx = 0;

    always #4 clk = ~clk;

    dram_interleave_seq dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .phi2(phi2), .ras_n(ras_n), .mux_n(mux_n), .cas_n(cas_n),
        .we_n(we_n), .dq_to_cpu(dq_to_cpu), .ma(ma)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc_idx);
        end
    endtask

    task automatic test_reset();
        repeat (3) begin
            @(negedge clk);
            chk("R11 idle pins", {phi2, ras_n, mux_n, cas_n, we_n, dq_to_cpu, ma},
                {1'b0, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0, 8'h00});
        end
        rst = 1'b0;
    endtask

    // One full CPU cycle, checked tick by tick
    task automatic run_cycle(input logic [15:0] a, input logic rd);
        int cas_ticks = 0;
        cpu_addr = a;
        cpu_rd   = rd;
        for (int s = 0; s < 2*HALF; s++) begin
            int  p  = s % HALF;
            bit  hi = (s >= HALF);
            bit  ca = hi && (p >= CASP);
            logic [3:0] ecas = ca ? ~(4'b0001 << a[15:14]) : 4'hF;
            logic [7:0] ema;
            if (!hi)           ema = cyc_idx[7:0];
            else if (p < COLP) ema = {a[15], a[13:8], a[14]};
            else               ema = a[7:0];
            @(negedge clk);
            chk("R1 phi2", {31'b0, phi2}, {31'b0, hi});
            chk("R2 ras_n", {31'b0, ras_n}, {31'b0, (p < HOLD)});
            chk("R3 mux_n", {31'b0, mux_n}, {31'b0, (p < COLP)});
            chk(hi ? "R5 cas_n bank" : "R4 cas_n quiet", {28'b0, cas_n}, {28'b0, ecas});
            chk("R9 we_n", {31'b0, we_n}, {31'b0, !(ca && !rd)});
            chk("R10 dq_to_cpu", {31'b0, dq_to_cpu}, {31'b0, (ca && rd)});
            chk(hi ? "R8 cpu address" : "R7 refresh row", {24'b0, ma}, {24'b0, ema});
            if (cas_n != 4'hF) cas_ticks++;
        end
        chk("R6 cas window", cas_ticks, 2*HALF - HALF - CASP);
        cyc_idx++;
    endtask

    task automatic test_banks();
        for (int b = 0; b < 4; b++) begin
            run_cycle({b[1:0], 14'h1234}, 1'b1);
            run_cycle({b[1:0], 14'h2A5B}, 1'b0);
        end
    endtask

    task automatic test_patterns();
        run_cycle(16'hFFFF, 1'b1);
        run_cycle(16'h0000, 1'b0);
        run_cycle(16'hA5C3, 1'b1);
        run_cycle(16'h5A3C, 1'b0);
    endtask

    task automatic test_refresh_wrap();
        for (int i = 0; i < 250; i++)
            run_cycle(16'(i * 16'h0307 + 16'h4001), i[0]);
    endtask

    initial begin
        test_reset();
        test_banks();
        test_patterns();
        test_refresh_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule